// File: doc/BRIEF.md
# Tagged FIFO Host Register Bank for a Disk Controller

This block is the processor-facing register bank of a floppy disk controller. A small FIFO, two entries deep by default, sits between a CPU bus and the disk-side read and write engines. Each entry is 11 bits wide: an 8-bit byte plus three tags. One tag marks an address mark. One asks the write engine to insert a CRC. One records that the CRC was zero when a byte was read back from the disk. The CPU pushes bytes, marks and CRC tokens through the write registers and pops bytes through the data and mark registers. It watches the handshake register to pace its transfers. The engines use their own push and pop ports.

The bank also holds a sticky error register that keeps only the first fault until it is read, a 16-byte parameter RAM reached through a self-advancing pointer, and the mode, phase and setup registers that steer the engines.

Each bus access takes one clock while `bus_sel` is high. Read data appears on `bus_rdata` one cycle later and holds until the next read. When the CPU and an engine both push in the same cycle, the CPU push wins and the engine push is dropped. When both pop in the same cycle, the CPU pop wins and the engine receives no strobe.

Top module: `fdc_host_regs`

## Requirements
- R1: An engine pop request (`dsk_pop`) on a non-empty FIFO removes the oldest entry. One cycle later `dsk_pop_ok` pulses for one cycle and `dsk_pop_word` carries that entry: bits 7:0 are the byte, bit 8 is the mark tag, bit 9 is the CRC-insert tag and bit 10 is the CRC-zero tag. A request on an empty FIFO produces no strobe.
- R2: Bus write address 0 pushes the byte with no tags. Address 1 pushes the byte with bit 8 set. Address 2 pushes the token 0x200 (bit 9 set, byte ignored).
- R3: A CPU push while the FIFO holds the configured depth of entries is dropped and raises error bit 2 (0x04).
- R4: Bus read address 0 pops the oldest entry and returns its byte. On an empty FIFO it returns 0xFF and raises error bit 2 (0x04). Popping an entry whose mark tag is set raises error bit 1 (0x02).
- R5: Bus read address 1 also pops and returns the byte. On an empty FIFO it returns 0xFF and raises 0x04. A mark-tagged entry popped here raises no error.
- R6: Error bits are captured only while the error register is zero, so later faults leave the first value untouched. Bus read address 2 returns the error value and clears it.
- R7: Handshake (bus read address 7) works as follows. Bit 0 is the mark tag of the newest entry. Bit 1 is set when the newest entry lacks the CRC-zero tag. Both bits are 0 when the FIFO is empty. Bit 3 is `drv_absent` OR `wr_prot`. Bit 5 is set while the error register is nonzero. Bits 2 and 4 are 0.
- R8: Handshake bits 7 and 6 depend on the transfer direction. With mode bit 4 set (write direction), an empty FIFO gives 0b11, one entry gives 0b10 and a full FIFO gives 0b00. With mode bit 4 clear (read direction), a full FIFO gives 0b11, one entry gives 0b10 and an empty FIFO gives 0b00.
- R9: Bus address 3 reads or writes the parameter RAM at the pointer, and the pointer then advances modulo 16. `eng_param_val` shows RAM entry `eng_param_idx`.
- R10: Write address 6 clears the mode bits that are 1 in the data. Write address 7 sets them. Read address 6 returns the mode. Addresses 4 and 5 store and return the phase and setup bytes. After any bus write that leaves mode bit 0 at 1, the FIFO is empty.
- R11: After reset the FIFO is empty, and the error register, mode and parameter pointer are zero. No pop strobe is driven.
- R12: Nonzero `err_in` bits from the engines enter the error register under the same first-fault rule as R6.
- R13: Read data is valid on `bus_rdata` in the cycle after the access and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after access |
| dsk_push | input | 1 | Engine push request |
| dsk_push_word | input | 11 | Engine entry to push |
| dsk_pop | input | 1 | Engine pop request |
| dsk_pop_ok | output | 1 | One-cycle strobe for a valid engine pop |
| dsk_pop_word | output | 11 | Entry delivered with the strobe |
| err_in | input | 8 | Engine error bits |
| drv_absent | input | 1 | No drive selected |
| wr_prot | input | 1 | Disk write-protected |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO at depth |
| mode_o | output | 8 | Mode register |
| phase_o | output | 8 | Phase register |
| setup_o | output | 8 | Setup register |
| eng_param_idx | input | 4 | Engine parameter index |
| eng_param_val | output | 8 | Parameter RAM entry at that index |

## Verification
Every register side effect takes hold at the clock edge of the access. A read's data, and any error or FIFO change it causes, can therefore be seen at the very next edge. The engine pop strobe and word come from registers and are due exactly one cycle after the request. The scoreboard holds one expected byte per bus read and compares it at the falling edge that follows the read's capture edge, so each result is sampled in the one cycle it is due. Handshake, error and engine-pop checks are issued only after the stimulus that changes them has crossed its edge.

// File: rtl/fdc_regs_pkg.sv
// Shared constants for the disk controller host register bank.
// Assumes an 8-bit CPU bus with a 3-bit register address.
package fdc_regs_pkg;
    localparam int BYTE_W   = 8;
    localparam int ENTRY_W  = 11;
    localparam int TAG_MARK = 8;
    localparam int TAG_CRCI = 9;
    localparam int TAG_CRCZ = 10;

    // register addresses
    localparam logic [2:0] RA_DATA  = 3'd0;
    localparam logic [2:0] RA_MARK  = 3'd1;
    localparam logic [2:0] RA_ERRCR = 3'd2;
    localparam logic [2:0] RA_PARAM = 3'd3;
    localparam logic [2:0] RA_PHASE = 3'd4;
    localparam logic [2:0] RA_SETUP = 3'd5;
    localparam logic [2:0] RA_MODEC = 3'd6;
    localparam logic [2:0] RA_MODES = 3'd7;

    // error bit values
    localparam logic [7:0] EB_MARKPOP = 8'h02;
    localparam logic [7:0] EB_XFER    = 8'h04;
endpackage

// File: rtl/fdc_tag_fifo.sv
// Shallow shift FIFO of tagged entries. Entry 0 is always the oldest.
// Assumes DEPTH >= 2. A push and a pop may happen in the same cycle.
// Fullness and emptiness are judged on the count before the edge. clr wins over both.
module fdc_tag_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 11,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [W-1:0]  head,
    output logic [W-1:0]  newest,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  ent [DEPTH];
    logic          pop_ok, push_ok;
    logic [CW-1:0] wr_pos;

    // accept only legal operations and find the slot for the new entry
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        pop_ok  = pop && !empty;
        push_ok = push && !full;
        wr_pos  = pop_ok ? count - CW'(1) : count;
        head    = ent[0];
        newest  = empty ? '0 : ent[IW'(count - CW'(1))];
    end

    // occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else count <= count + {{(CW-1){1'b0}}, push_ok} - {{(CW-1){1'b0}}, pop_ok};
    end

    // per-slot storage: load the pushed entry or shift toward the head
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i < DEPTH - 1) begin : g_mid
            always_ff @(posedge clk) begin
                if (push_ok && wr_pos == CW'(i)) ent[i] <= push_data;
                else if (pop_ok) ent[i] <= ent[i+1];
            end
        end else begin : g_last
            always_ff @(posedge clk) begin
                if (push_ok && wr_pos == CW'(i)) ent[i] <= push_data;
            end
        end
    end
endmodule

// File: rtl/fdc_param_ram.sv
// Small parameter RAM behind one auto-advancing pointer, plus a direct read port
// for the engines. The contents are not reset; the pointer is.
module fdc_param_ram #(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          we,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic [PW-1:0] ptr,
    input  logic [PW-1:0] eng_idx,
    output logic [7:0]    eng_val
);
    logic [7:0] mem [DEPTH];

    // pointer steps once per access and wraps at the depth
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (acc) ptr <= ptr + PW'(1);
    end

    // storage write at the pointer
    always_ff @(posedge clk) begin
        if (acc && we) mem[ptr] <= wdata;
    end

    assign rdata   = mem[ptr];
    assign eng_val = mem[eng_idx];
endmodule

// File: rtl/fdc_err_latch.sv
// First-fault error register: it captures new bits only while empty.
// A read clears it, and a fault in the same cycle as the read is captured.
module fdc_err_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic         rd_clr,
    output logic [W-1:0] err_q
);
    logic [W-1:0] base;

    // value the register would hold without new faults
    always_comb base = rd_clr ? '0 : err_q;

    // capture the first fault only
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else if (base == '0) err_q <= set_bits;
        else err_q <= base;
    end
endmodule

// File: rtl/fdc_host_regs.sv
// Host register bank of a disk controller: decodes CPU accesses to a tagged FIFO,
// the error latch, the parameter RAM and the mode, phase and setup registers.
// It also forms the handshake status. Accesses are single-cycle, with read data
// registered. The CPU has priority over the engines on the shared FIFO ports.
module fdc_host_regs
    import fdc_regs_pkg::*;
#(
    parameter int FIFO_DEPTH = 2,
    parameter int PRM_DEPTH  = 16,
    localparam int CW        = $clog2(FIFO_DEPTH + 1),
    localparam int PW        = $clog2(PRM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [2:0]         bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic               dsk_push,
    input  logic [ENTRY_W-1:0] dsk_push_word,
    input  logic               dsk_pop,
    output logic               dsk_pop_ok,
    output logic [ENTRY_W-1:0] dsk_pop_word,
    input  logic [7:0]         err_in,
    input  logic               drv_absent,
    input  logic               wr_prot,
    output logic               fifo_empty,
    output logic               fifo_full,
    output logic [7:0]         mode_o,
    output logic [7:0]         phase_o,
    output logic [7:0]         setup_o,
    input  logic [PW-1:0]      eng_param_idx,
    output logic [7:0]         eng_param_val
);
    logic               acc_rd, acc_wr, cpu_pop, cpu_push, fifo_clr;
    logic               f_push, f_pop, dsk_take;
    logic [ENTRY_W-1:0] cpu_word, f_wdata, f_head, f_newest;
    logic [CW-1:0]      fifo_cnt;
    logic [7:0]         mode_nx, err_set, err_val, hs, rd_mux, prm_rd;
    logic [PW-1:0]      prm_ptr;
    logic               err_rd;

    // bus decode and the entry a CPU write would push
    always_comb begin
        acc_rd   = bus_sel && !bus_we;
        acc_wr   = bus_sel && bus_we;
        cpu_pop  = acc_rd && (bus_addr == RA_DATA || bus_addr == RA_MARK);
        cpu_push = acc_wr && (bus_addr == RA_DATA || bus_addr == RA_MARK || bus_addr == RA_ERRCR);
        err_rd   = acc_rd && bus_addr == RA_ERRCR;
        cpu_word = '0;
        if (bus_addr == RA_ERRCR) cpu_word[TAG_CRCI] = 1'b1;
        else begin
            cpu_word[BYTE_W-1:0] = bus_wdata;
            cpu_word[TAG_MARK]   = (bus_addr == RA_MARK);
        end
    end

    // mode value after this cycle's write, and the clear it triggers
    always_comb begin
        mode_nx = mode_o;
        if (acc_wr && bus_addr == RA_MODEC) mode_nx = mode_o & ~bus_wdata;
        if (acc_wr && bus_addr == RA_MODES) mode_nx = mode_o | bus_wdata;
        fifo_clr = acc_wr && mode_nx[0];
    end

    // FIFO port arbitration with CPU priority
    always_comb begin
        f_push   = cpu_push || dsk_push;
        f_wdata  = cpu_push ? cpu_word : dsk_push_word;
        dsk_take = dsk_pop && !cpu_pop && !fifo_empty && !fifo_clr;
        f_pop    = cpu_pop || dsk_take;
    end

    fdc_tag_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(f_push), .push_data(f_wdata),
        .pop(f_pop), .count(fifo_cnt), .head(f_head), .newest(f_newest),
        .full(fifo_full), .empty(fifo_empty)
    );

    // error sources from CPU transfers and the engines
    always_comb begin
        err_set = err_in;
        if (cpu_pop && fifo_empty) err_set = err_set | EB_XFER;
        if (cpu_pop && !fifo_empty && bus_addr == RA_DATA && f_head[TAG_MARK])
            err_set = err_set | EB_MARKPOP;
        if (cpu_push && fifo_full) err_set = err_set | EB_XFER;
    end

    fdc_err_latch #(.W(8)) u_err (
        .clk(clk), .rst_n(rst_n), .set_bits(err_set), .rd_clr(err_rd), .err_q(err_val)
    );

    fdc_param_ram #(.DEPTH(PRM_DEPTH)) u_prm (
        .clk(clk), .rst_n(rst_n), .acc(bus_sel && bus_addr == RA_PARAM), .we(bus_we),
        .wdata(bus_wdata), .rdata(prm_rd), .ptr(prm_ptr),
        .eng_idx(eng_param_idx), .eng_val(eng_param_val)
    );

    // handshake status, direction-dependent fill bits
    always_comb begin
        hs    = '0;
        hs[0] = f_newest[TAG_MARK];
        hs[1] = !fifo_empty && !f_newest[TAG_CRCZ];
        hs[3] = drv_absent || wr_prot;
        hs[5] = (err_val != '0);
        if (mode_o[4]) begin
            hs[7] = !fifo_full;
            hs[6] = fifo_empty;
        end else begin
            hs[7] = !fifo_empty;
            hs[6] = fifo_full;
        end
    end

    // read data selection
    always_comb begin
        case (bus_addr)
            RA_DATA, RA_MARK: rd_mux = fifo_empty ? 8'hFF : f_head[BYTE_W-1:0];
            RA_ERRCR:         rd_mux = err_val;
            RA_PARAM:         rd_mux = prm_rd;
            RA_PHASE:         rd_mux = phase_o;
            RA_SETUP:         rd_mux = setup_o;
            RA_MODEC:         rd_mux = mode_o;
            default:          rd_mux = hs;
        endcase
    end

    // control registers and registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o    <= '0;
            phase_o   <= '0;
            setup_o   <= '0;
            bus_rdata <= '0;
        end else begin
            mode_o <= mode_nx;
            if (acc_wr && bus_addr == RA_PHASE) phase_o <= bus_wdata;
            if (acc_wr && bus_addr == RA_SETUP) setup_o <= bus_wdata;
            if (acc_rd) bus_rdata <= rd_mux;
        end
    end

    // engine pop strobe and delivered entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsk_pop_ok   <= 1'b0;
            dsk_pop_word <= '0;
        end else begin
            dsk_pop_ok <= dsk_take;
            if (dsk_take) dsk_pop_word <= f_head;
        end
    end
endmodule

// File: rtl/fdc_host_regs_chk.sv
// Property checker for the host register bank, bound to every instance.
module fdc_host_regs_chk #(
    parameter int DEPTH = 2,
    parameter int PW    = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [2:0]    bus_addr,
    input logic          dsk_push,
    input logic          dsk_pop,
    input logic          dsk_pop_ok,
    input logic [7:0]    mode_o,
    input logic [CW-1:0] fifo_cnt,
    input logic [7:0]    err_val,
    input logic [PW-1:0] prm_ptr
);
    logic err_rd, cpu_pop, prm_acc, bus_wr;
    assign err_rd  = bus_sel && !bus_we && bus_addr == 3'd2;
    assign cpu_pop = bus_sel && !bus_we && bus_addr <= 3'd1;
    assign prm_acc = bus_sel && bus_addr == 3'd3;
    assign bus_wr  = bus_sel && bus_we;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH)); // R3
    AST_POP_STROBE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_pop_ok |-> $past(dsk_pop) && $past(fifo_cnt) != '0); // R1
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(err_val) != '0 && !$past(err_rd) |-> err_val == $past(err_val)); // R6
    AST_FIFO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_wr) && mode_o[0] |-> fifo_cnt == '0); // R10
    AST_PARAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(prm_acc) |-> prm_ptr == $past(prm_ptr) + PW'(1)); // R9
    AST_CPU_POP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cpu_pop) && $past(fifo_cnt) != '0 && !$past(dsk_push)
        |-> fifo_cnt == $past(fifo_cnt) - CW'(1)); // R4
endmodule

bind fdc_host_regs fdc_host_regs_chk #(.DEPTH(FIFO_DEPTH), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .dsk_push(dsk_push), .dsk_pop(dsk_pop), .dsk_pop_ok(dsk_pop_ok), .mode_o(mode_o),
    .fifo_cnt(fifo_cnt), .err_val(err_val), .prm_ptr(prm_ptr)
);

// File: tb/fdc_host_regs_bench.sv
module fdc_host_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        dsk_push = 1'b0, dsk_pop = 1'b0;
    logic [10:0] dsk_push_word = '0;
    logic        dsk_pop_ok;
    logic [10:0] dsk_pop_word;
    logic [7:0]  err_in = '0;
    logic        drv_absent = 1'b0, wr_prot = 1'b0;
    logic        fifo_empty, fifo_full;
    logic [7:0]  mode_o, phase_o, setup_o;
    logic [3:0]  eng_param_idx = '0;
    logic [7:0]  eng_param_val;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_pend = 1'b0;

    always #5 clk = ~clk;

    fdc_host_regs u_fdc_host_regs (.*);

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: bus write
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // driver: bus read, expected byte goes to the scoreboard
    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic dpush(input logic [10:0] w);
        @(negedge clk);
        dsk_push = 1'b1; dsk_push_word = w;
        @(negedge clk);
        dsk_push = 1'b0;
    endtask

    task automatic dpop(input bit exp_ok, input logic [10:0] exp_w, input string req);
        @(negedge clk);
        dsk_pop = 1'b1;
        @(negedge clk);
        dsk_pop = 1'b0;
        chk(dsk_pop_ok == exp_ok, req, 16'(dsk_pop_ok), 16'(exp_ok));
        if (exp_ok) chk(dsk_pop_word == exp_w, req, 16'(dsk_pop_word), 16'(exp_w));
    endtask

    task automatic epulse(input logic [7:0] e);
        @(negedge clk);
        err_in = e;
        @(negedge clk);
        err_in = '0;
    endtask

    // monitor: a read captured at the last rising edge is compared here
    always @(posedge clk) rd_pend <= rst_n && bus_sel && !bus_we;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) chk(1'b0, "R13", 16'(bus_rdata), 16'hxxxx);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata == e, t, 16'(bus_rdata), 16'(e));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk(fifo_empty == 1'b1, "R11", 16'(fifo_empty), 16'h1);
        chk(dsk_pop_ok == 1'b0, "R11", 16'(dsk_pop_ok), 16'h0);
        rd(3'd6, 8'h00, "R11 mode");
        rd(3'd2, 8'h00, "R11 error");
        rd(3'd7, 8'h00, "R11 handshake");
        wr(3'd3, 8'hA5);
        eng_param_idx = 4'd0;
        #1 chk(eng_param_val == 8'hA5, "R11 pointer", 16'(eng_param_val), 16'hA5);

        // read direction, CPU pushes (R2 R7 R8)
        wr(3'd0, 8'h3C);
        wr(3'd1, 8'hA1);
        rd(3'd7, 8'hC3, "R8 full read dir");
        wr(3'd0, 8'h99);
        rd(3'd2, 8'h04, "R3 push full");
        rd(3'd2, 8'h00, "R6 cleared by read");
        rd(3'd0, 8'h3C, "R4 pop plain");
        rd(3'd2, 8'h00, "R4 no error on plain");
        rd(3'd7, 8'h83, "R7 newest mark");
        rd(3'd0, 8'hA1, "R4 pop mark");
        rd(3'd2, 8'h02, "R4 mark pop error");
        wr(3'd1, 8'h55);
        rd(3'd0, 8'h55, "R4 pop mark 2");
        rd(3'd1, 8'hFF, "R5 empty mark pop");
        rd(3'd2, 8'h02, "R6 first fault kept");
        rd(3'd2, 8'h00, "R6 clear");
        rd(3'd7, 8'h00, "R8 empty read dir");
        rd(3'd0, 8'hFF, "R4 empty pop");
        rd(3'd2, 8'h04, "R4 empty error");
        wr(3'd1, 8'h77);
        rd(3'd1, 8'h77, "R5 mark read");
        rd(3'd2, 8'h00, "R5 no mark error");

        // engine pops (R1 R2)
        wr(3'd2, 8'h5A);
        wr(3'd0, 8'h12);
        dpop(1'b1, 11'h200, "R2 crc token");
        dpop(1'b1, 11'h012, "R1 plain word");
        dpop(1'b0, 11'h000, "R1 empty no strobe");
        wr(3'd1, 8'h34);
        dpop(1'b1, 11'h134, "R2 mark word");

        // write direction (R8) and FIFO clear (R10)
        wr(3'd7, 8'h10);
        rd(3'd6, 8'h10, "R10 mode set");
        rd(3'd7, 8'hC0, "R8 empty write dir");
        wr(3'd0, 8'h01);
        rd(3'd7, 8'h82, "R8 one write dir");
        wr(3'd0, 8'h02);
        rd(3'd7, 8'h02, "R8 full write dir");
        wr(3'd7, 8'h01);
        rd(3'd7, 8'hC0, "R10 clear on mode bit");
        wr(3'd0, 8'h05);
        chk(fifo_empty == 1'b1, "R10 held clear", 16'(fifo_empty), 16'h1);
        wr(3'd6, 8'h11);
        rd(3'd6, 8'h00, "R10 mode clear");
        rd(3'd2, 8'h00, "R10 no error");

        // engine pushes in read direction (R7)
        dpush(11'h4AB);
        rd(3'd7, 8'h80, "R7 crc zero present");
        rd(3'd0, 8'hAB, "R4 engine byte");
        dpush(11'h1CD);
        rd(3'd7, 8'h83, "R7 mark no crc zero");
        rd(3'd1, 8'hCD, "R5 engine mark");

        // drive status and engine errors (R7 R12)
        drv_absent = 1'b1;
        rd(3'd7, 8'h08, "R7 no drive");
        drv_absent = 1'b0; wr_prot = 1'b1;
        rd(3'd7, 8'h08, "R7 write protect");
        wr_prot = 1'b0;
        epulse(8'h01);
        rd(3'd7, 8'h20, "R12 pending error");
        epulse(8'h10);
        rd(3'd2, 8'h01, "R12 first engine fault");
        rd(3'd2, 8'h00, "R12 cleared");

        // phase and setup (R10)
        wr(3'd4, 8'h0F);
        rd(3'd4, 8'h0F, "R10 phase");
        wr(3'd5, 8'h44);
        rd(3'd5, 8'h44, "R10 setup");

        // parameter RAM wrap (R9)
        for (int k = 1; k < 16; k++) wr(3'd3, 8'(8'h10 + k));
        rd(3'd3, 8'hA5, "R9 wrap");
        rd(3'd3, 8'h11, "R9 step");
        rd(3'd3, 8'h12, "R9 step 2");
        eng_param_idx = 4'd15;
        #1 chk(eng_param_val == 8'h1F, "R9 engine port", 16'(eng_param_val), 16'h1F);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R13 drained", 16'(exp_q.size()), 16'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule